// File: doc/BRIEF.md
# Hash Engine Command and Status Registers

This block is the register front end of a hash accelerator. A 32-bit, word-addressed write/read port reaches a small file of words. It holds the source pointer, the destination pointer, the key pointer, the source byte count, a cipher command word and a hash command word. Each pointer and length word is masked on the way in, so the stored value is always aligned and within range. A status word carries a sticky completion flag.

A write to the hash command word is decoded as it is written. The algorithm comes from two fields: a family selector, and a variant selector that applies only to the 512-bit family. When the code is legal, a three-state sequencer issues a one-cycle start pulse to the external hash datapath. With the pulse it presents the decoded algorithm code, the accumulate flag and the scatter-gather flag. The sequencer then waits for the datapath's one-cycle done pulse. Completion always sets the status flag. The interrupt line rises only when the launching command asked for it. Software acknowledges by writing the status word.

The sequencer states are IDLE, LAUNCH and WAIT. The transitions are:
- IDLE to LAUNCH on a legal command write.
- LAUNCH to WAIT unconditionally, after the single start cycle.
- WAIT to IDLE when done arrives.

Top module: `hash_ctl_regs`

## Requirements
- R1: Reset clears every stored word, the completion flag, the interrupt line and the start pulse, and returns the sequencer to IDLE. All reads then return zero and `hs_alg` reads 0.
- R2: Each write is masked before it is stored. With default parameters:
  - source (byte 0x20) keeps `0x7FFFFFFF`;
  - destination (0x24) keeps `0x7FFFFFF8`;
  - key (0x28) keeps `0x7FFFFFF8`;
  - length (0x2C) keeps `0x0FFFFFFF`;
  - hash command (0x30) keeps `0x00147FFF`.

  A read returns the masked value. Word index is the byte address with bits [1:0] dropped.
- R3: Command bits [6:4] select the family: 000 MD5 (code 0), 010 SHA-1 (code 1), 100 SHA-224 (code 2), 101 SHA-256 (code 3). Family 110 uses bits [12:10] to pick the variant: 000 SHA-512 (code 4), 001 SHA-384 (code 5), 010 SHA-512/256 (code 6). Outside family 110, bits [12:10] must be 000.
- R4: Any other combination of those six bits is illegal. An illegal command produces no start pulse, no flag and no interrupt, but the command word is still stored.
- R5: After a legal command write, `hs_start` is high for exactly the one cycle that follows the write edge. In that cycle `hs_alg` carries the code from R3, `hs_accum` is 1 only when bits [8:7] are 10, and `hs_sg` equals bit 18.
- R6: While in WAIT, a done pulse sets status bit 9 whatever command bit 9 held. `irq` rises at the same edge only if bit 9 of the launching command was 1.
- R7: A write to status (0x1C) stores the data with bit 9 cleared, and the completion flag clears. `irq` falls only when the written bit 9 is 1 and the flag was set.
- R8: A word index of 13 or more reads as zero. A write there changes nothing.
- R9: The cipher command word (0x10) stores all 32 bits and never causes a start, flag or interrupt.
- R10: A command write outside IDLE is stored but starts nothing. A done pulse outside WAIT is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | AW (8) | Byte address; bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data of the addressed word |
| hs_start | output | 1 | One-cycle launch pulse to the hash datapath |
| hs_alg | output | 3 | Decoded algorithm code, held from launch |
| hs_accum | output | 1 | Accumulate mode flag, held from launch |
| hs_sg | output | 1 | Scatter-gather input flag, held from launch |
| hs_done | input | 1 | One-cycle completion pulse from the datapath |
| irq | output | 1 | Interrupt request level |

## Verification
Read data is combinational, so a stored value is checked in the same cycle the address is presented, one edge after its write. `hs_start` is due one edge after the command write and must be gone one edge later. The flag and `irq` are due at the edge that samples `hs_done` in WAIT, and `irq` falls at the edge that samples the acknowledging status write. Inputs change on the falling clock edge, and every check samples just after a falling edge. Each check therefore lands in the exact cycle named above, and a result one cycle early or late fails.

// File: rtl/hash_ctl_pkg.sv
package hash_ctl_pkg;

    typedef enum logic [2:0] {
        ALG_MD5        = 3'd0,
        ALG_SHA1       = 3'd1,
        ALG_SHA224     = 3'd2,
        ALG_SHA256     = 3'd3,
        ALG_SHA512     = 3'd4,
        ALG_SHA384     = 3'd5,
        ALG_SHA512_256 = 3'd6,
        ALG_NONE       = 3'd7
    } hash_alg_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_WAIT   = 2'd2
    } seq_st_e;

    typedef struct packed {
        hash_alg_e alg;
        logic      accum;
        logic      sg;
        logic      irq_en;
    } launch_t;

    // command word field positions
    localparam int FAM_LO    = 4;
    localparam int MODE_LO   = 7;
    localparam int IRQEN_BIT = 9;
    localparam int SUB_LO    = 10;
    localparam int SG_BIT    = 18;
    localparam int DONE_BIT  = 9;

    // word indices
    localparam int IDX_CRYPT = 4;
    localparam int IDX_STAT  = 7;
    localparam int IDX_SRC   = 8;
    localparam int IDX_DST   = 9;
    localparam int IDX_KEY   = 10;
    localparam int IDX_LEN   = 11;
    localparam int IDX_CMD   = 12;

endpackage

// File: rtl/hash_ctl_decode.sv
module hash_ctl_decode
    import hash_ctl_pkg::*;
(
    input  logic [2:0] fam,
    input  logic [2:0] sub,
    input  logic [1:0] mode,
    input  logic       irq_bit,
    input  logic       sg_bit,
    output launch_t    req,
    output logic       legal
);

    hash_alg_e alg;

    always_comb begin
        alg = ALG_NONE;
        if (fam == 3'b110) begin
            case (sub)
                3'b000:  alg = ALG_SHA512;
                3'b001:  alg = ALG_SHA384;
                3'b010:  alg = ALG_SHA512_256;
                default: alg = ALG_NONE;
            endcase
        end else if (sub == 3'b000) begin
            case (fam)
                3'b000:  alg = ALG_MD5;
                3'b010:  alg = ALG_SHA1;
                3'b100:  alg = ALG_SHA224;
                3'b101:  alg = ALG_SHA256;
                default: alg = ALG_NONE;
            endcase
        end
    end

    always_comb begin
        req.alg    = alg;
        req.accum  = (mode == 2'b10);
        req.sg     = sg_bit;
        req.irq_en = irq_bit;
        legal      = (alg != ALG_NONE);
    end

endmodule

// File: rtl/hash_ctl_seq.sv
module hash_ctl_seq
    import hash_ctl_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cmd_wr,
    input  logic    cmd_ok,
    input  launch_t req_in,
    input  logic    hs_done,
    output logic    hs_start,
    output logic    complete,
    output launch_t cur
);

    seq_st_e state, nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // next-state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (cmd_wr && cmd_ok) nxt = ST_LAUNCH;
            ST_LAUNCH: nxt = ST_WAIT;
            ST_WAIT:   if (hs_done) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // launch parameters captured on IDLE -> LAUNCH
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur <= '{alg: ALG_MD5, accum: 1'b0, sg: 1'b0, irq_en: 1'b0};
        end else if (state == ST_IDLE && cmd_wr && cmd_ok) begin
            cur <= req_in;
        end
    end

    // outputs
    always_comb begin
        hs_start = (state == ST_LAUNCH);
        complete = (state == ST_WAIT) && hs_done;
    end

endmodule

// File: rtl/hash_ctl_regs.sv
module hash_ctl_regs
    import hash_ctl_pkg::*;
#(
    parameter int          AW        = 8,
    parameter int          REG_WORDS = 13,
    parameter logic [31:0] SRC_MASK  = 32'h7FFF_FFFF,
    parameter logic [31:0] DST_MASK  = 32'h7FFF_FFF8,
    parameter logic [31:0] KEY_MASK  = 32'h7FFF_FFF8,
    parameter logic [31:0] LEN_MASK  = 32'h0FFF_FFFF,
    parameter logic [31:0] CMD_MASK  = 32'h0014_7FFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          hs_start,
    output logic [2:0]    hs_alg,
    output logic          hs_accum,
    output logic          hs_sg,
    input  logic          hs_done,
    output logic          irq
);

    localparam int IDX_W = AW - 2;
    localparam int RW_W  = $clog2(REG_WORDS);

    logic [IDX_W-1:0] idx;
    logic [RW_W-1:0]  slot;
    logic             in_range;
    logic             unused_lsb;
    logic [31:0]      wmask;
    logic [31:0]      regs [REG_WORDS];
    logic             done_flag;
    logic             irq_q;
    logic             cmd_wr, stat_wr;
    logic [31:0]      cmd_m;
    launch_t          req, cur;
    logic             cmd_ok, complete;

    assign idx        = bus_addr[AW-1:2];
    assign slot       = idx[RW_W-1:0];
    assign in_range   = (idx < IDX_W'(REG_WORDS));
    assign unused_lsb = ^bus_addr[1:0];
    assign cmd_wr     = bus_we && (idx == IDX_W'(IDX_CMD));
    assign stat_wr    = bus_we && (idx == IDX_W'(IDX_STAT));
    assign cmd_m      = bus_wdata & CMD_MASK;

    always_comb begin
        case (idx)
            IDX_W'(IDX_SRC):  wmask = SRC_MASK;
            IDX_W'(IDX_DST):  wmask = DST_MASK;
            IDX_W'(IDX_KEY):  wmask = KEY_MASK;
            IDX_W'(IDX_LEN):  wmask = LEN_MASK;
            IDX_W'(IDX_CMD):  wmask = CMD_MASK;
            IDX_W'(IDX_STAT): wmask = ~(32'd1 << DONE_BIT);
            default:          wmask = 32'hFFFF_FFFF;
        endcase
    end

    hash_ctl_decode u_dec (
        .fam     (cmd_m[FAM_LO +: 3]),
        .sub     (cmd_m[SUB_LO +: 3]),
        .mode    (cmd_m[MODE_LO +: 2]),
        .irq_bit (cmd_m[IRQEN_BIT]),
        .sg_bit  (cmd_m[SG_BIT]),
        .req     (req),
        .legal   (cmd_ok)
    );

    hash_ctl_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (cmd_wr),
        .cmd_ok   (cmd_ok),
        .req_in   (req),
        .hs_done  (hs_done),
        .hs_start (hs_start),
        .complete (complete),
        .cur      (cur)
    );

    // word storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_WORDS; i++) begin
                regs[i] <= '0;
            end
        end else if (bus_we && in_range) begin
            regs[slot] <= bus_wdata & wmask;
        end
    end

    // completion flag and interrupt; completion wins over acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_flag <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            if (complete) begin
                done_flag <= 1'b1;
            end else if (stat_wr) begin
                done_flag <= 1'b0;
            end
            if (complete && cur.irq_en) begin
                irq_q <= 1'b1;
            end else if (stat_wr && bus_wdata[DONE_BIT] && done_flag) begin
                irq_q <= 1'b0;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (in_range) begin
            bus_rdata = regs[slot];
            if (idx == IDX_W'(IDX_STAT)) begin
                bus_rdata[DONE_BIT] = done_flag;
            end
        end
    end

    assign hs_alg   = cur.alg;
    assign hs_accum = cur.accum;
    assign hs_sg    = cur.sg;
    assign irq      = irq_q;

endmodule

// File: rtl/hash_ctl_chk.sv
module hash_ctl_chk
    import hash_ctl_pkg::*;
#(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic          wd9,
    input logic          hs_start,
    input logic [2:0]    hs_alg,
    input logic          hs_done,
    input logic          irq,
    input logic          flag
);

    localparam logic [AW-3:0] CMD_I  = (AW-2)'(IDX_CMD);
    localparam logic [AW-3:0] STAT_I = (AW-2)'(IDX_STAT);

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        hs_start |=> !hs_start); // R5
    AST_START_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        hs_start |-> $past(bus_we && bus_addr[AW-1:2] == CMD_I)); // R5
    AST_START_LEGAL_ALG: assert property (@(posedge clk) disable iff (!rst_n)
        hs_start |-> hs_alg != 3'd7); // R4
    AST_FLAG_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(hs_done)); // R6
    AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> flag); // R6
    AST_IRQ_FALL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(bus_we && bus_addr[AW-1:2] == STAT_I && wd9)); // R7

endmodule

bind hash_ctl_regs hash_ctl_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .wd9      (bus_wdata[9]),
    .hs_start (hs_start),
    .hs_alg   (hs_alg),
    .hs_done  (hs_done),
    .irq      (irq),
    .flag     (done_flag)
);

// File: tb/hash_ctl_regs_test.sv
module hash_ctl_regs_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        hs_start, hs_accum, hs_sg, irq;
    logic [2:0]  hs_alg;
    logic        hs_done = 1'b0;

    int total = 0;
    int bad = 0;

    localparam logic [7:0] A_CRYPT = 8'h10, A_STAT = 8'h1C, A_SRC = 8'h20,
                           A_DST = 8'h24, A_KEY = 8'h28, A_LEN = 8'h2C,
                           A_CMD = 8'h30;

    typedef struct packed {
        logic [31:0] cmd;
        logic        ok;
        logic [2:0]  alg;
        logic        acc;
        logic        sg;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0000, 1'b1, 3'd0, 1'b0, 1'b0},
        '{32'h0000_0220, 1'b1, 3'd1, 1'b0, 1'b0},
        '{32'h0000_0040, 1'b1, 3'd2, 1'b0, 1'b0},
        '{32'h0000_0250, 1'b1, 3'd3, 1'b0, 1'b0},
        '{32'h0000_0260, 1'b1, 3'd4, 1'b0, 1'b0},
        '{32'h0000_0460, 1'b1, 3'd5, 1'b0, 1'b0},
        '{32'h0000_0A60, 1'b1, 3'd6, 1'b0, 1'b0},
        '{32'h0004_0350, 1'b1, 3'd3, 1'b1, 1'b1},
        '{32'h0000_00D0, 1'b1, 3'd3, 1'b0, 1'b0},
        '{32'h0000_0C60, 1'b0, 3'd0, 1'b0, 1'b0},
        '{32'h0000_0210, 1'b0, 3'd0, 1'b0, 1'b0},
        '{32'h0000_0070, 1'b0, 3'd0, 1'b0, 1'b0},
        '{32'h0000_0620, 1'b0, 3'd0, 1'b0, 1'b0},
        '{32'h0000_1260, 1'b0, 3'd0, 1'b0, 1'b0},
        '{32'h0000_0030, 1'b0, 3'd0, 1'b0, 1'b0}
    };

    hash_ctl_regs uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .hs_start  (hs_start),
        .hs_alg    (hs_alg),
        .hs_accum  (hs_accum),
        .hs_sg     (hs_sg),
        .hs_done   (hs_done),
        .irq       (irq)
    );

    always #4 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic done_pulse();
        @(negedge clk);
        hs_done = 1'b1;
        @(negedge clk);
        hs_done = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 start", {31'd0, hs_start}, 32'd0);
        check("R1 alg", {29'd0, hs_alg}, 32'd0);
        rd("R1 cmd", A_CMD, 32'd0);
        rd("R1 stat", A_STAT, 32'd0);

        // table of commands: R3 R4 R5 R6 R7
        for (int k = 0; k < NV; k++) begin
            wr(A_CMD, VECS[k].cmd);
            check($sformatf("R5 start v%0d", k), {31'd0, hs_start}, {31'd0, VECS[k].ok});
            if (VECS[k].ok) begin
                check($sformatf("R3 alg v%0d", k), {29'd0, hs_alg}, {29'd0, VECS[k].alg});
                check($sformatf("R5 acc v%0d", k), {31'd0, hs_accum}, {31'd0, VECS[k].acc});
                check($sformatf("R5 sg v%0d", k), {31'd0, hs_sg}, {31'd0, VECS[k].sg});
            end
            rd($sformatf("R4 cmd stored v%0d", k), A_CMD, VECS[k].cmd);
            @(negedge clk); #1;
            check($sformatf("R5 start gone v%0d", k), {31'd0, hs_start}, 32'd0);
            done_pulse(); #1;
            rd($sformatf("R6 flag v%0d", k), A_STAT, {22'd0, VECS[k].ok, 9'd0});
            check($sformatf("R6 irq v%0d", k), {31'd0, irq}, {31'd0, VECS[k].ok & VECS[k].cmd[9]});
            wr(A_STAT, 32'h0000_0200); #1;
            rd($sformatf("R7 flag clr v%0d", k), A_STAT, 32'd0);
            check($sformatf("R7 irq clr v%0d", k), {31'd0, irq}, 32'd0);
        end

        // R2 masks
        wr(A_SRC, 32'hFFFF_FFFF); rd("R2 src", A_SRC, 32'h7FFF_FFFF);
        wr(A_DST, 32'hFFFF_FFFF); rd("R2 dst", A_DST, 32'h7FFF_FFF8);
        wr(A_KEY, 32'hFFFF_FFFF); rd("R2 key", A_KEY, 32'h7FFF_FFF8);
        wr(A_LEN, 32'hFFFF_FFFF); rd("R2 len", A_LEN, 32'h0FFF_FFFF);
        wr(A_CMD, 32'h8020_0250);
        check("R2 masked cmd starts", {31'd0, hs_start}, 32'd1);
        rd("R2 cmd", A_CMD, 32'h0000_0250);
        done_pulse();
        wr(A_STAT, 32'h0000_0200);

        // R9 cipher command word
        wr(A_CRYPT, 32'hFFFF_FFFF);
        check("R9 no start", {31'd0, hs_start}, 32'd0);
        rd("R9 stored", A_CRYPT, 32'hFFFF_FFFF);
        done_pulse(); #1;
        check("R9 no irq", {31'd0, irq}, 32'd0);

        // R8 out of range
        wr(8'h00, 32'd0);
        wr(8'h40, 32'h1234_5678);
        rd("R8 read oob", 8'h40, 32'd0);
        rd("R8 no alias", 8'h00, 32'd0);
        rd("R8 read top", 8'hFC, 32'd0);

        // R7 status write with bit9 clear leaves irq high
        wr(A_CMD, 32'h0000_0250);
        done_pulse(); #1;
        check("R6 irq up", {31'd0, irq}, 32'd1);
        wr(A_STAT, 32'h0000_0001); #1;
        rd("R7 other bits kept", A_STAT, 32'h0000_0001);
        check("R7 irq stays", {31'd0, irq}, 32'd1);
        wr(A_STAT, 32'h0000_0200); #1;
        check("R7 no flag no lower", {31'd0, irq}, 32'd1);
        rd("R7 bit9 not stored", A_STAT, 32'd0);
        wr(A_CMD, 32'h0000_0220);
        done_pulse();
        wr(A_STAT, 32'h0000_0200); #1;
        check("R7 lowered", {31'd0, irq}, 32'd0);

        // R10 command while busy, done while idle
        done_pulse(); #1;
        rd("R10 idle done ignored", A_STAT, 32'd0);
        wr(A_CMD, 32'h0000_0250);
        wr(A_CMD, 32'h0000_0020);
        check("R10 busy no start", {31'd0, hs_start}, 32'd0);
        check("R10 alg kept", {29'd0, hs_alg}, 32'd3);
        rd("R10 busy cmd stored", A_CMD, 32'h0000_0020);
        done_pulse(); #1;
        check("R10 first irq", {31'd0, irq}, 32'd1);
        @(negedge clk); #1;
        check("R10 no late start", {31'd0, hs_start}, 32'd0);

        // R1 reset mid-operation
        wr(A_CMD, 32'h0004_0350);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 irq mid", {31'd0, irq}, 32'd0);
        check("R1 sg mid", {31'd0, hs_sg}, 32'd0);
        rd("R1 cmd mid", A_CMD, 32'd0);
        rd("R1 stat mid", A_STAT, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        done_pulse(); #1;
        rd("R1 idle after reset", A_STAT, 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule